// File: doc/BRIEF.md
# Two-descriptor DMA channel engine

This block moves data for one DMA channel using two descriptor slots, slot 0 (the primary) and slot 1 (the alternate). Each slot holds three 32-bit words: the end address of the source region, the end address of the destination region and a control word. Software loads the slots through a small write port and reads them back through a combinational read port. The engine updates each slot's control word as it works, so an unfinished transfer shows how many elements are still to go, and a finished slot shows that it has been used.

Three cycle kinds are supported. A basic cycle is paced by a peripheral request. An auto-request cycle is memory to memory: one software request runs it to the end. A ping-pong cycle starts on the primary slot and, each time a slot finishes, switches to the other slot and keeps going while that slot holds a valid cycle kind. Every element is one read on the memory master followed by one write of the same data in the next cycle. The arbitration field R limits a run to 2^R elements before the engine goes back to waiting for a grant.

States: `ST_IDLE` (channel off), `ST_CHECK` (decode the selected slot), `ST_WAIT` (wait for a grant), `ST_READ` (read an element), `ST_WRITE` (write it), `ST_BLOCK` (write back the remaining count after a run of 2^R), `ST_FINISH` (retire the slot). Transitions: IDLE→CHECK on `start`. CHECK→IDLE if the slot kind is stop, otherwise CHECK→WAIT. WAIT→READ on a grant. READ→WRITE always. WRITE→FINISH on the last element, WRITE→BLOCK when the run reaches 2^R, otherwise WRITE→READ. BLOCK→WAIT always. FINISH→CHECK when a ping-pong slot is followed by a non-stop slot, otherwise FINISH→IDLE.

Top module: `dma_pp_engine`

## Requirements
- R1: After reset `busy`, `done`, `cur_alt` and both memory strobes are low, and every descriptor word reads back as zero.
- R2: A write on the load port stores `cfg_wdata` into slot `cfg_alt`, word `cfg_sel` (0 source end, 1 destination end, 2 control), and reads back unchanged; the control word is laid out as kind [1:0] (0 stop, 1 basic, 2 auto-request, 3 ping-pong), n_minus_1 [11:2], R [15:12], size [17:16] (0 byte, 1 halfword, 2 word), source step [19:18] and destination step [21:20].
- R3: For element i of a slot with count field n_minus_1, the address is end − ((n_minus_1 − i) << step), where step code 0, 1, 2 shifts by 0, 1, 2 and step code 3 keeps the address fixed at the end value; elements run from i = 0 to n_minus_1.
- R4: Each element is one read cycle followed directly by one write cycle that carries the read data unchanged, with `mem_size` equal to the slot's size field; the two strobes are never high together.
- R5: An auto-request slot starts on a single `sw_req` pulse, runs every run of 2^R elements without further requests, and ignores `per_req`.
- R6: A basic or ping-pong slot transfers at most 2^R elements per `per_req` grant (R of 10 or more means the whole slot), and `sw_req` has no effect on it.
- R7: When a run of 2^R elements ends and elements remain, the slot's n_minus_1 field is rewritten to the number of remaining elements minus one, all other control fields unchanged.
- R8: When a slot's last element is written, its kind field becomes 0 and its n_minus_1 field becomes 0, all other control fields unchanged.
- R9: `done` is a single-cycle pulse raised when the final slot of an activation completes, and `busy` is low in the following cycle.
- R10: `start` selects the starting slot with `start_alt`; in ping-pong operation `cur_alt` toggles each time a slot completes and the engine continues on the other slot.
- R11: A ping-pong sequence stops after a slot whose successor's kind is stop, and a successor of kind basic runs once and then ends the sequence.
- R12: Starting on a slot whose kind is stop returns to idle without any memory access and without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor word write strobe |
| cfg_alt | input | 1 | Slot selected for the write |
| cfg_sel | input | 2 | Word selected for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_ralt | input | 1 | Slot selected for readback |
| cfg_rsel | input | 2 | Word selected for readback |
| cfg_rdata | output | 32 | Readback data |
| start | input | 1 | Enable the channel |
| start_alt | input | 1 | Slot the activation begins on |
| sw_req | input | 1 | Software request pulse |
| per_req | input | 1 | Peripheral request |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Read address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | 32 | Write data |
| mem_size | output | 2 | Element size code |
| busy | output | 1 | Channel enabled |
| cur_alt | output | 1 | Slot in use |
| done | output | 1 | Activation complete pulse |

## Verification
A grant reaches the read strobe one or two cycles later (one through CHECK when it came early and was held pending, directly from WAIT otherwise), the write follows its read by exactly one cycle, and `done` comes one cycle after the last write with `busy` low one cycle after that. Because the grant latency varies, the bench does not count cycles to writes: its driver queues the expected address, data and size of every element and a monitor compares each write against the queue head as it appears, sampling on the falling edge. Readback of the control words is combinational and is sampled only after the engine has settled in WAIT or IDLE, several cycles after the last grant.

// File: rtl/dma_pp_pkg.sv
package dma_pp_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 10;
    localparam int RUN_W  = CNT_W + 1;

    typedef enum logic [1:0] {
        CYC_STOP     = 2'd0,
        CYC_BASIC    = 2'd1,
        CYC_AUTO     = 2'd2,
        CYC_PINGPONG = 2'd3
    } cyc_e;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_DST  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    localparam logic [1:0] STEP_FIXED = 2'd3;

    typedef struct packed {
        logic [9:0]       spare;
        logic [1:0]       dst_step;
        logic [1:0]       src_step;
        logic [1:0]       size;
        logic [3:0]       r_pow;
        logic [CNT_W-1:0] n_m1;
        cyc_e             kind;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_BLOCK,
        ST_FINISH
    } state_e;

endpackage

// File: rtl/dma_pp_desc_bank.sv
module dma_pp_desc_bank
    import dma_pp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic              sw_alt,
    input  logic [1:0]        sw_sel,
    input  logic [WORD_W-1:0] sw_data,
    input  logic              wb_en,
    input  logic              wb_alt,
    input  ctrl_t             wb_ctrl,
    input  logic              rd_alt,
    input  logic [1:0]        rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic              cur_alt,
    output logic [AW-1:0]     cur_src,
    output logic [AW-1:0]     cur_dst,
    output ctrl_t             cur_ctrl,
    output cyc_e              next_kind
);

    localparam int SLOTS = 2;

    logic [AW-1:0] src_q  [SLOTS];
    logic [AW-1:0] dst_q  [SLOTS];
    ctrl_t         ctrl_q [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) begin
                src_q[s]  <= '0;
                dst_q[s]  <= '0;
                ctrl_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < SLOTS; s++) begin
                if (sw_we && (sw_alt == 1'(s)) && (sel_e'(sw_sel) == SEL_SRC))
                    src_q[s] <= sw_data[AW-1:0];
                if (sw_we && (sw_alt == 1'(s)) && (sel_e'(sw_sel) == SEL_DST))
                    dst_q[s] <= sw_data[AW-1:0];
                if (wb_en && (wb_alt == 1'(s)))
                    ctrl_q[s] <= wb_ctrl;
                else if (sw_we && (sw_alt == 1'(s)) && (sel_e'(sw_sel) == SEL_CTRL))
                    ctrl_q[s] <= ctrl_t'(sw_data);
            end
        end
    end

    always_comb begin
        unique case (sel_e'(rd_sel))
            SEL_SRC:  rd_data = WORD_W'(src_q[rd_alt]);
            SEL_DST:  rd_data = WORD_W'(dst_q[rd_alt]);
            SEL_CTRL: rd_data = WORD_W'(ctrl_q[rd_alt]);
            default:  rd_data = '0;
        endcase
    end

    assign cur_src   = src_q[cur_alt];
    assign cur_dst   = dst_q[cur_alt];
    assign cur_ctrl  = ctrl_q[cur_alt];
    assign next_kind = ctrl_q[~cur_alt].kind;

endmodule

// File: rtl/dma_pp_addr.sv
module dma_pp_addr
    import dma_pp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    end_addr,
    input  logic [CNT_W-1:0] remain,
    input  logic [1:0]       step,
    output logic [AW-1:0]    addr
);

    logic [AW-1:0] offset;

    always_comb begin
        offset = AW'(remain) << step;
        if (step == STEP_FIXED)
            addr = end_addr;
        else
            addr = end_addr - offset;
    end

endmodule

// File: rtl/dma_pp_engine.sv
module dma_pp_engine
    import dma_pp_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_alt,
    input  logic [1:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              cfg_ralt,
    input  logic [1:0]        cfg_rsel,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              start,
    input  logic              start_alt,
    input  logic              sw_req,
    input  logic              per_req,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data,
    output logic [1:0]        mem_size,
    output logic              busy,
    output logic              cur_alt,
    output logic              done
);

    localparam int SIDES = 2;
    localparam logic [3:0] R_WHOLE = 4'(CNT_W);

    state_e           state_q, state_d;
    logic             alt_q;
    logic [CNT_W-1:0] rem_q;
    logic [RUN_W-1:0] run_q;
    cyc_e             mode_q;
    logic             sw_pend_q, per_pend_q, auto_go_q;

    logic [AW-1:0]    cur_src, cur_dst;
    ctrl_t            cur_ctrl;
    cyc_e             next_kind;
    logic             wb_en;
    ctrl_t            wb_ctrl;

    logic             go, run_last, chain, last_elem;
    logic [RUN_W-1:0] run_lim;

    logic [AW-1:0]    end_a  [SIDES];
    logic [1:0]       step_a [SIDES];
    logic [AW-1:0]    addr_a [SIDES];

    dma_pp_desc_bank #(.AW(AW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_we     (cfg_we),
        .sw_alt    (cfg_alt),
        .sw_sel    (cfg_sel),
        .sw_data   (cfg_wdata),
        .wb_en     (wb_en),
        .wb_alt    (alt_q),
        .wb_ctrl   (wb_ctrl),
        .rd_alt    (cfg_ralt),
        .rd_sel    (cfg_rsel),
        .rd_data   (cfg_rdata),
        .cur_alt   (alt_q),
        .cur_src   (cur_src),
        .cur_dst   (cur_dst),
        .cur_ctrl  (cur_ctrl),
        .next_kind (next_kind)
    );

    assign end_a[0]  = cur_src;
    assign end_a[1]  = cur_dst;
    assign step_a[0] = cur_ctrl.src_step;
    assign step_a[1] = cur_ctrl.dst_step;

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        dma_pp_addr #(.AW(AW)) u_addr (
            .end_addr (end_a[g]),
            .remain   (rem_q),
            .step     (step_a[g]),
            .addr     (addr_a[g])
        );
    end

    // grant and run bookkeeping
    always_comb begin
        if (mode_q == CYC_AUTO)
            go = sw_pend_q | sw_req | auto_go_q;
        else
            go = per_pend_q | per_req;
        if (cur_ctrl.r_pow >= R_WHOLE)
            run_lim = RUN_W'(1) << CNT_W;
        else
            run_lim = RUN_W'(1) << cur_ctrl.r_pow;
        run_last  = (run_q + RUN_W'(1)) == run_lim;
        last_elem = (rem_q == '0);
        chain     = (mode_q == CYC_PINGPONG) && (next_kind != CYC_STOP);
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CHECK;
            ST_CHECK:  state_d = (cur_ctrl.kind == CYC_STOP) ? ST_IDLE : ST_WAIT;
            ST_WAIT:   if (go) state_d = ST_READ;
            ST_READ:   state_d = ST_WRITE;
            ST_WRITE: begin
                if (last_elem)     state_d = ST_FINISH;
                else if (run_last) state_d = ST_BLOCK;
                else               state_d = ST_READ;
            end
            ST_BLOCK:  state_d = ST_WAIT;
            ST_FINISH: state_d = chain ? ST_CHECK : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alt_q      <= 1'b0;
            rem_q      <= '0;
            run_q      <= '0;
            mode_q     <= CYC_STOP;
            sw_pend_q  <= 1'b0;
            per_pend_q <= 1'b0;
            auto_go_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                sw_pend_q  <= 1'b0;
                per_pend_q <= 1'b0;
            end else if ((state_q == ST_WAIT) && go) begin
                sw_pend_q  <= (mode_q == CYC_AUTO) ? 1'b0 : (sw_pend_q | sw_req);
                per_pend_q <= (mode_q == CYC_AUTO) ? (per_pend_q | per_req) : 1'b0;
            end else begin
                sw_pend_q  <= sw_pend_q | sw_req;
                per_pend_q <= per_pend_q | per_req;
            end

            unique case (state_q)
                ST_IDLE: if (start) alt_q <= start_alt;
                ST_CHECK: begin
                    rem_q     <= cur_ctrl.n_m1;
                    mode_q    <= cur_ctrl.kind;
                    auto_go_q <= 1'b0;
                end
                ST_WAIT: if (go) begin
                    run_q     <= '0;
                    auto_go_q <= 1'b0;
                end
                ST_WRITE: if (!last_elem) begin
                    rem_q <= rem_q - CNT_W'(1);
                    run_q <= run_q + RUN_W'(1);
                end
                ST_BLOCK:  auto_go_q <= (mode_q == CYC_AUTO);
                ST_FINISH: if (mode_q == CYC_PINGPONG) alt_q <= ~alt_q;
                default: ;
            endcase
        end
    end

    // outputs and write-back
    always_comb begin
        wb_ctrl     = cur_ctrl;
        wb_en       = 1'b0;
        mem_rd_en   = 1'b0;
        mem_wr_en   = 1'b0;
        done        = 1'b0;
        mem_rd_addr = addr_a[0];
        mem_wr_addr = addr_a[1];
        mem_wr_data = mem_rd_data;
        mem_size    = cur_ctrl.size;
        busy        = (state_q != ST_IDLE);
        cur_alt     = alt_q;
        unique case (state_q)
            ST_READ:  mem_rd_en = 1'b1;
            ST_WRITE: mem_wr_en = 1'b1;
            ST_BLOCK: begin
                wb_en        = 1'b1;
                wb_ctrl.n_m1 = rem_q;
            end
            ST_FINISH: begin
                wb_en        = 1'b1;
                wb_ctrl.n_m1 = '0;
                wb_ctrl.kind = CYC_STOP;
                done         = !chain;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dma_pp_checker.sv
module dma_pp_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic mem_rd_en,
    input logic mem_wr_en
);

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en)); // R4

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en)); // R4

    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> mem_wr_en); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(mem_rd_en || mem_wr_en)); // R12

endmodule

bind dma_pp_engine dma_pp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en)
);

// File: tb/sim_dma_pp_engine.sv
module sim_dma_pp_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_alt = 1'b0, cfg_ralt = 1'b0;
    logic [1:0]  cfg_sel = 2'd0, cfg_rsel = 2'd0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        start = 1'b0, start_alt = 1'b0, sw_req = 1'b0, per_req = 1'b0;
    logic        mem_rd_en, mem_wr_en, busy, cur_alt, done;
    logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic [31:0] mem_rd_data = '0;
    logic [1:0]  mem_size;

    int total = 0, bad = 0, wr_cnt = 0, done_cnt = 0;
    bit finished = 0;
    logic [65:0] exp_q[$];

    always #2 clk = ~clk;

    dma_pp_engine #(.AW(32)) u0 (.*);

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'hC3C3_0000;
    endfunction

    function automatic logic [31:0] mk_ctrl(input logic [1:0] kind, input logic [9:0] n,
        input logic [3:0] r, input logic [1:0] sz, input logic [1:0] si, input logic [1:0] di);
        return {10'd0, di, si, sz, r, n, kind};
    endfunction

    function automatic logic [31:0] elem_addr(input logic [31:0] e, input int rem,
                                              input logic [1:0] st);
        if (st == 2'd3) return e;
        return e - (32'(rem) << st);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: queue the expected element writes of one slot
    task automatic push_slot(input logic [31:0] s, input logic [31:0] d, input int n,
        input logic [1:0] sz, input logic [1:0] si, input logic [1:0] di);
        for (int i = 0; i <= n; i++) begin
            exp_q.push_back({elem_addr(d, n - i, di), pat(elem_addr(s, n - i, si)), sz});
        end
    endtask

    task automatic wr_desc(input logic alt, input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_alt = alt; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_desc(input logic alt, input logic [1:0] sel, output logic [31:0] v);
        cfg_ralt = alt; cfg_rsel = sel;
        #1 v = cfg_rdata;
    endtask

    task automatic pulse_start(input logic alt);
        @(negedge clk);
        start = 1'b1; start_alt = alt;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_req = 1'b1;
        @(negedge clk); sw_req = 1'b0;
    endtask

    task automatic pulse_per();
        @(negedge clk); per_req = 1'b1;
        @(negedge clk); per_req = 1'b0;
    endtask

    task automatic idle_wait(input string req);
        int n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check({req, " engine returns idle"}, 32'(busy), 32'd0);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bench memory: read data one cycle after the strobe
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= pat(mem_rd_addr);

    // monitor: compare every write with the queue head
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (mem_wr_en) begin
                wr_cnt++;
                if (exp_q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R4: unexpected write actual=%h expected=none", mem_wr_addr);
                end else begin
                    logic [65:0] e;
                    e = exp_q.pop_front();
                    check("R3 write address", mem_wr_addr, e[65:34]);
                    check("R4 write data", mem_wr_data, e[33:2]);
                    check("R4 element size", 32'(mem_size), 32'(e[1:0]));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int w0, d0;

        cycles(3);
        rst_n = 1'b1;
        cycles(2);

        // R1: reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        check("R1 cur_alt", 32'(cur_alt), 0);
        check("R1 memory strobes", 32'({mem_rd_en, mem_wr_en}), 0);
        rd_desc(1'b1, 2'd0, v); check("R1 alt source end", v, 0);
        rd_desc(1'b0, 2'd2, v); check("R1 primary control", v, 0);

        // R2 and R5: auto-request, primary slot, word steps, whole slot in one run
        wr_desc(1'b0, 2'd0, 32'h0000_0100);
        wr_desc(1'b0, 2'd1, 32'h0000_0800);
        wr_desc(1'b0, 2'd2, mk_ctrl(2'd2, 10'd3, 4'd10, 2'd2, 2'd2, 2'd2));
        rd_desc(1'b0, 2'd0, v); check("R2 source readback", v, 32'h0000_0100);
        rd_desc(1'b0, 2'd2, v); check("R2 control readback", v, mk_ctrl(2'd2, 10'd3, 4'd10, 2'd2, 2'd2, 2'd2));
        pulse_start(1'b0);
        cycles(3);
        pulse_per();
        cycles(6);
        check("R5 peripheral request ignored", 32'(wr_cnt), 0);
        push_slot(32'h100, 32'h800, 3, 2'd2, 2'd2, 2'd2);
        pulse_sw();
        idle_wait("R5");
        check("R5 all elements written", 32'(exp_q.size()), 0);
        check("R9 one done pulse", 32'(done_cnt), 1);
        rd_desc(1'b0, 2'd2, v); check("R8 retired control", v, mk_ctrl(2'd0, 10'd0, 4'd10, 2'd2, 2'd2, 2'd2));

        // R5 and R7: auto-request on alternate, R=0, fixed source, byte destination
        wr_desc(1'b1, 2'd0, 32'h0000_0A00);
        wr_desc(1'b1, 2'd1, 32'h0000_0C10);
        wr_desc(1'b1, 2'd2, mk_ctrl(2'd2, 10'd2, 4'd0, 2'd0, 2'd3, 2'd0));
        push_slot(32'hA00, 32'hC10, 2, 2'd0, 2'd3, 2'd0);
        pulse_start(1'b1);
        cycles(2);
        pulse_sw();
        idle_wait("R7");
        check("R7 runs continue without request", 32'(exp_q.size()), 0);
        check("R9 second done pulse", 32'(done_cnt), 2);
        check("R10 starting slot kept", 32'(cur_alt), 1);

        // R6 and R7: basic, halfword steps, R=1
        wr_desc(1'b0, 2'd0, 32'h0000_1000);
        wr_desc(1'b0, 2'd1, 32'h0000_1400);
        wr_desc(1'b0, 2'd2, mk_ctrl(2'd1, 10'd5, 4'd1, 2'd1, 2'd1, 2'd1));
        pulse_start(1'b0);
        cycles(3);
        w0 = wr_cnt;
        pulse_sw();
        cycles(8);
        check("R6 software request ignored", 32'(wr_cnt - w0), 0);
        rd_desc(1'b0, 2'd2, v); check("R6 count untouched", 32'(v[11:2]), 5);
        push_slot(32'h1000, 32'h1400, 5, 2'd1, 2'd1, 2'd1);
        pulse_per();
        cycles(10);
        check("R6 one run per grant", 32'(wr_cnt - w0), 2);
        check("R6 still enabled", 32'(busy), 1);
        rd_desc(1'b0, 2'd2, v); check("R7 remaining count", v, mk_ctrl(2'd1, 10'd3, 4'd1, 2'd1, 2'd1, 2'd1));
        pulse_per();
        cycles(10);
        rd_desc(1'b0, 2'd2, v); check("R7 remaining count after second run", 32'(v[11:2]), 1);
        pulse_per();
        idle_wait("R6");
        check("R6 all elements written", 32'(exp_q.size()), 0);
        rd_desc(1'b0, 2'd2, v); check("R8 basic retired", v, mk_ctrl(2'd0, 10'd0, 4'd1, 2'd1, 2'd1, 2'd1));

        // R10 and R11: ping-pong both slots, then halt on the retired primary
        d0 = done_cnt;
        wr_desc(1'b0, 2'd0, 32'h0000_2000);
        wr_desc(1'b0, 2'd1, 32'h0000_2100);
        wr_desc(1'b0, 2'd2, mk_ctrl(2'd3, 10'd1, 4'd10, 2'd2, 2'd2, 2'd2));
        wr_desc(1'b1, 2'd0, 32'h0000_3000);
        wr_desc(1'b1, 2'd1, 32'h0000_3100);
        wr_desc(1'b1, 2'd2, mk_ctrl(2'd3, 10'd2, 4'd10, 2'd2, 2'd2, 2'd2));
        push_slot(32'h2000, 32'h2100, 1, 2'd2, 2'd2, 2'd2);
        push_slot(32'h3000, 32'h3100, 2, 2'd2, 2'd2, 2'd2);
        @(negedge clk); per_req = 1'b1;
        pulse_start(1'b0);
        idle_wait("R11");
        per_req = 1'b0;
        check("R10 both slots transferred", 32'(exp_q.size()), 0);
        check("R10 slot toggled twice", 32'(cur_alt), 0);
        check("R11 single done at halt", 32'(done_cnt - d0), 1);
        rd_desc(1'b1, 2'd2, v); check("R8 alternate retired", 32'(v[11:0]), 0);

        // R10 and R11: ping-pong followed by a basic slot
        d0 = done_cnt;
        wr_desc(1'b0, 2'd0, 32'h0000_4000);
        wr_desc(1'b0, 2'd1, 32'h0000_4100);
        wr_desc(1'b0, 2'd2, mk_ctrl(2'd3, 10'd0, 4'd10, 2'd2, 2'd2, 2'd2));
        wr_desc(1'b1, 2'd0, 32'h0000_5000);
        wr_desc(1'b1, 2'd1, 32'h0000_5100);
        wr_desc(1'b1, 2'd2, mk_ctrl(2'd1, 10'd1, 4'd10, 2'd2, 2'd2, 2'd2));
        push_slot(32'h4000, 32'h4100, 0, 2'd2, 2'd2, 2'd2);
        push_slot(32'h5000, 32'h5100, 1, 2'd2, 2'd2, 2'd2);
        @(negedge clk); per_req = 1'b1;
        pulse_start(1'b0);
        idle_wait("R11");
        per_req = 1'b0;
        check("R11 basic successor ends sequence", 32'(exp_q.size()), 0);
        check("R10 ended on alternate", 32'(cur_alt), 1);
        check("R11 done once", 32'(done_cnt - d0), 1);

        // R12: start on a stop slot
        d0 = done_cnt;
        w0 = wr_cnt;
        pulse_start(1'b0);
        cycles(8);
        check("R12 back to idle", 32'(busy), 0);
        check("R12 no memory traffic", 32'(wr_cnt - w0), 0);
        check("R12 no done", 32'(done_cnt - d0), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule